// File: doc/BRIEF.md
# Shared Level Interrupt Aggregator

This block folds the level-sensitive interrupt requests of a set of endpoint devices onto a small number of shared interrupt lines. Every device drives four request pins. Each pin is steered onto an output line by a rotation that depends on the device's slot number. If the device sits behind a bridge, the bridge's own slot number rotates the result once more. The block does not OR the sources together. It keeps one counter per output line and adjusts that counter only when a source changes level. An output line is high while its counter is nonzero.

The counters are visible on a debug port, which also serves as the save path. A restore port loads them back in a single cycle. A restore is accepted only when the line count it carries equals the configured line count. Device slots, bridge membership and the bridge slot are static strap inputs.

Top module: `irq_share_agg`

## Requirements
- R1: Pin p (0..3) of device d drives line (p + slot_d) mod N_LINE. The slot is bits [SLOT_W-1:0] of `slot_i` field d, and request bit d*4+p belongs to that pin.
- R2: A pin whose sampled level equals its remembered level changes no counter.
- R3: All pins that change level in one cycle have their +1 and −1 applied together at the next clock edge.
- R4: `line_o[l]` is 1 exactly when the counter of line l is nonzero.
- R5: For a device with `behind_i[d]`=1, the first line index is rotated again by `bridge_slot_i`, giving (first + bridge_slot) mod N_LINE.
- R6: After reset, every remembered level, every counter and `snap_reject_o` are 0.
- R7: When `snap_load_i`=1 and `snap_lines_i` equals N_LINE, every counter takes its field of `snap_cnt_i` at the next edge. Line l occupies bits [l*CW +: CW].
- R8: When `snap_load_i`=1 and `snap_lines_i` differs from N_LINE, `snap_reject_o` is 1 in the following cycle. Counters are then updated only by level changes, as if no restore had been requested.
- R9: Level changes present during an accepted restore are not lost. They are applied at the clock edge after the restore.
- R10: A counter holds every value up to N_DEV*4 without wrapping, and never goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | N_DEV*4 | Request levels, bit d*4+p |
| slot_i | input | N_DEV*SLOT_W | Static slot number per device |
| behind_i | input | N_DEV | Device sits behind the bridge |
| bridge_slot_i | input | SLOT_W | Slot number of the bridge |
| snap_load_i | input | 1 | Restore strobe |
| snap_lines_i | input | 8 | Line count carried by the snapshot |
| snap_cnt_i | input | N_LINE*CW | Counter values to restore |
| line_o | output | N_LINE | Shared interrupt lines |
| cnt_o | output | N_LINE*CW | Counter view, also the save path |
| snap_reject_o | output | 1 | Previous restore was refused |

## Verification
The request patterns cover the following cases:
- Single pins raised one at a time, to expose a wrong rotation.
- Whole devices raised, with and without the bridge rotation, to separate R1 from R5.
- A repeated vector, to show that an unchanged level moves nothing.
- A swap from one dense word to its mirror, where many pins rise and fall in the same cycle.
- An all-ones word, which drives each counter to its maximum.

Directed cases then cover three restore situations: a restore whose line count matches, a restore whose line count does not match, and a restore that coincides with a level change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned PINS_PER_DEV = 4;

    // rotate a line index by an offset within n lines
    function automatic int unsigned rot_line(int unsigned base, int unsigned ofs, int unsigned n);
        return (base + ofs) % n;
    endfunction
endpackage

// File: rtl/irq_route.sv
module irq_route
    import irq_agg_pkg::*;
#(
    parameter int unsigned SLOT_W = 5,
    parameter int unsigned N_LINE = 4,
    parameter int unsigned LW     = 2
) (
    input  logic [SLOT_W-1:0]          slot_i,
    input  logic                       behind_i,
    input  logic [SLOT_W-1:0]          bslot_i,
    output logic [PINS_PER_DEV*LW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int p = 0; p < PINS_PER_DEV; p++) begin
            int unsigned first;
            int unsigned second;
            first  = rot_line(p, int'(slot_i), N_LINE);
            second = behind_i ? rot_line(first, int'(bslot_i), N_LINE) : first;
            idx_o[p*LW +: LW] = LW'(second);
        end
    end
endmodule

// File: rtl/irq_delta.sv
module irq_delta #(
    parameter int unsigned NP     = 32,
    parameter int unsigned N_LINE = 4,
    parameter int unsigned LW     = 2,
    parameter int unsigned CW     = 6
) (
    input  logic [NP-1:0]        req_i,
    input  logic [NP-1:0]        lvl_i,
    input  logic [NP*LW-1:0]     idx_i,
    output logic [N_LINE*CW-1:0] inc_o,
    output logic [N_LINE*CW-1:0] dec_o
);
    logic [CW-1:0] inc_a [N_LINE];
    logic [CW-1:0] dec_a [N_LINE];

    always_comb begin
        for (int l = 0; l < N_LINE; l++) begin
            inc_a[l] = '0;
            dec_a[l] = '0;
        end
        for (int s = 0; s < NP; s++) begin
            if (req_i[s] != lvl_i[s]) begin
                if (req_i[s]) inc_a[idx_i[s*LW +: LW]] = inc_a[idx_i[s*LW +: LW]] + CW'(1);
                else          dec_a[idx_i[s*LW +: LW]] = dec_a[idx_i[s*LW +: LW]] + CW'(1);
            end
        end
    end

    for (genvar l = 0; l < N_LINE; l++) begin : g_pack
        assign inc_o[l*CW +: CW] = inc_a[l];
        assign dec_o[l*CW +: CW] = dec_a[l];
    end
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned N_DEV  = 8,
    parameter int unsigned N_LINE = 4,
    parameter int unsigned SLOT_W = 5,
    localparam int unsigned NP    = N_DEV * PINS_PER_DEV,
    localparam int unsigned LW    = (N_LINE > 1) ? $clog2(N_LINE) : 1,
    localparam int unsigned CW    = $clog2(NP + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NP-1:0]           req_i,
    input  logic [N_DEV*SLOT_W-1:0] slot_i,
    input  logic [N_DEV-1:0]        behind_i,
    input  logic [SLOT_W-1:0]       bridge_slot_i,
    input  logic                    snap_load_i,
    input  logic [7:0]              snap_lines_i,
    input  logic [N_LINE*CW-1:0]    snap_cnt_i,
    output logic [N_LINE-1:0]       line_o,
    output logic [N_LINE*CW-1:0]    cnt_o,
    output logic                    snap_reject_o
);
    typedef struct packed {
        logic [NP-1:0]        lvl;
        logic [N_LINE*CW-1:0] cnt;
        logic                 rej;
    } state_t;

    state_t st_d, st_q;

    logic [NP*LW-1:0]     idx;
    logic [N_LINE*CW-1:0] inc, dec;
    logic                 load_ok;

    for (genvar d = 0; d < N_DEV; d++) begin : g_route
        irq_route #(.SLOT_W(SLOT_W), .N_LINE(N_LINE), .LW(LW)) route_i (
            .slot_i   (slot_i[d*SLOT_W +: SLOT_W]),
            .behind_i (behind_i[d]),
            .bslot_i  (bridge_slot_i),
            .idx_o    (idx[d*PINS_PER_DEV*LW +: PINS_PER_DEV*LW])
        );
    end

    irq_delta #(.NP(NP), .N_LINE(N_LINE), .LW(LW), .CW(CW)) delta_i (
        .req_i (req_i),
        .lvl_i (st_q.lvl),
        .idx_i (idx),
        .inc_o (inc),
        .dec_o (dec)
    );

    assign load_ok = snap_load_i && (snap_lines_i == 8'(N_LINE));

    always_comb begin
        st_d     = st_q;
        st_d.rej = snap_load_i && !load_ok;
        if (load_ok) begin
            // level memory held so pending changes land next cycle
            st_d.cnt = snap_cnt_i;
        end else begin
            st_d.lvl = req_i;
            for (int l = 0; l < N_LINE; l++)
                st_d.cnt[l*CW +: CW] = st_q.cnt[l*CW +: CW] + inc[l*CW +: CW] - dec[l*CW +: CW];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        logic [CW-1:0] cnt_l;
        assign cnt_l     = st_q.cnt[l*CW +: CW];
        assign line_o[l] = (cnt_l != '0);

        // R10
        no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!load_ok && cnt_l == '0) |=> (cnt_l <= CW'(NP)));
    end

    assign cnt_o         = st_q.cnt;
    assign snap_reject_o = st_q.rej;

    // R2
    steady_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!snap_load_i && req_i == st_q.lvl) |=> $stable(cnt_o));

    // R7
    restore_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_ok |=> (cnt_o == $past(snap_cnt_i)));

    // R8
    restore_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snap_load_i && snap_lines_i != 8'(N_LINE)) |=> snap_reject_o);

    // R9
    restore_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_ok |=> $stable(st_q.lvl));
endmodule

// File: tb/irq_share_agg_tb.sv
module irq_share_agg_tb_top;
    localparam int N_DEV = 8, N_LINE = 4, SLOT_W = 5;
    localparam int NP = N_DEV * 4;
    localparam int CW = $clog2(NP + 1);
    localparam int NV = 12;
    localparam logic [NP-1:0] VEC [NV] = '{
        32'h0000_0001, 32'h0000_0003, 32'h0000_000F, 32'h0000_00F0,
        32'h0000_00F0, 32'hF000_0000, 32'h0F00_0000, 32'hFFFF_FFFF,
        32'h1234_5678, 32'h8765_4321, 32'h0000_0000, 32'h8000_0001};

    logic clk = 0, rst_ni = 0;
    logic [NP-1:0] req = '0;
    logic [N_DEV*SLOT_W-1:0] slot;
    logic [N_DEV-1:0] behind = 8'hC0;
    logic [SLOT_W-1:0] bslot = 5'd1;
    logic snap_load = 0;
    logic [7:0] snap_lines = 8'd4;
    logic [N_LINE*CW-1:0] snap_cnt = '0;
    logic [N_LINE-1:0] line;
    logic [N_LINE*CW-1:0] cnt;
    logic rej;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    for (genvar d = 0; d < N_DEV; d++) begin : g_slot
        assign slot[d*SLOT_W +: SLOT_W] = SLOT_W'(d);
    end

    irq_share_agg #(.N_DEV(N_DEV), .N_LINE(N_LINE), .SLOT_W(SLOT_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .slot_i(slot),
        .behind_i(behind), .bridge_slot_i(bslot), .snap_load_i(snap_load),
        .snap_lines_i(snap_lines), .snap_cnt_i(snap_cnt), .line_o(line),
        .cnt_o(cnt), .snap_reject_o(rej));

    // independent model of the routing and counting rules
    function automatic logic [N_LINE*CW-1:0] model(logic [NP-1:0] r);
        int c [N_LINE];
        logic [N_LINE*CW-1:0] v;
        for (int l = 0; l < N_LINE; l++) c[l] = 0;
        for (int d = 0; d < N_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (r[d*4+p]) c[(p + d + (behind[d] ? int'(bslot) : 0)) % N_LINE]++;
        for (int l = 0; l < N_LINE; l++) v[l*CW +: CW] = CW'(c[l]);
        return v;
    endfunction

    function automatic logic [N_LINE-1:0] nz(logic [N_LINE*CW-1:0] v);
        logic [N_LINE-1:0] m;
        for (int l = 0; l < N_LINE; l++) m[l] = (v[l*CW +: CW] != '0);
        return m;
    endfunction

    function automatic logic [N_LINE*CW-1:0] pk(int a, int b, int c, int d);
        return {CW'(d), CW'(c), CW'(b), CW'(a)};
    endfunction

    task automatic chk(string tag, logic [N_LINE*CW-1:0] ec, logic ej);
        checks++;
        if (cnt !== ec || line !== nz(ec) || rej !== ej) begin
            fails++;
            $display("FAIL %s: cnt=%h line=%b rej=%b expected cnt=%h line=%b rej=%b",
                     tag, cnt, line, rej, ec, nz(ec), ej);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 0; req = '0; snap_load = 0;
        @(negedge clk);
        @(negedge clk);
        rst_ni = 1;
    endtask

    initial begin
        do_reset();
        chk("R6 reset state", '0, 1'b0);

        // R1 R3 R4 R5 R10 vectors through the routing model
        for (int i = 0; i < NV; i++) begin
            req = VEC[i];
            @(negedge clk);
            chk($sformatf("R1/R3/R4/R5/R10 vector %0d", i), model(VEC[i]), 1'b0);
        end
        // R2 repeated level
        @(negedge clk);
        chk("R2 unchanged levels", model(VEC[NV-1]), 1'b0);
        // R10 full load
        req = '1;
        @(negedge clk);
        chk("R10 all pins", pk(8, 8, 8, 8), 1'b0);
        // R5 bridge device alone
        req = 32'h0100_0000;
        @(negedge clk);
        chk("R5 bridged pin", pk(0, 0, 0, 1), 1'b0);

        // R7 and R9: restore with a coincident change
        do_reset();
        snap_load = 1; snap_lines = 8'd4; snap_cnt = pk(1, 1, 1, 1); req = 32'h1;
        @(negedge clk);
        snap_load = 0;
        chk("R7 restore taken", pk(1, 1, 1, 1), 1'b0);
        @(negedge clk);
        chk("R9 deferred change", pk(2, 1, 1, 1), 1'b0);

        // R8 refused restore
        do_reset();
        req = 32'h0000_000F;
        @(negedge clk);
        chk("R8 setup", pk(1, 1, 1, 1), 1'b0);
        snap_load = 1; snap_lines = 8'd3; snap_cnt = '0; req = 32'h0000_0001;
        @(negedge clk);
        snap_load = 0;
        chk("R8 refused", pk(1, 0, 0, 0), 1'b1);
        @(negedge clk);
        chk("R8 flag clears", pk(1, 0, 0, 0), 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule